// File: doc/BRIEF.md
# Grouped Four-Way Dot-Product Accumulator

This datapath unit takes in one accumulator vector and two source vectors. Each 128-bit segment of the sources is cut into groups of four neighbouring narrow elements. The unit multiplies each group element by element and sums the four products at full precision. It then adds that sum into the accumulator lane that sits in the same position as the group. The final add wraps at the lane width, and no overflow indication is produced.

One select input makes the source elements signed (two's complement) or unsigned. A second select chooses the width pairing: 8-bit elements feeding 32-bit lanes, or 16-bit elements feeding 64-bit lanes. The parameter `SEGS` sets how many 128-bit segments are processed side by side, and each segment is independent of the others.

Operands enter through a valid/ready handshake, and the result leaves through another. A single output register sits between the two, so the result appears one cycle after the operands are accepted. If the consumer stalls, that register holds its value.

Top module: `dot4_accum`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and `result` is all zeros until the first accepted input.
- R2: When `in_valid` and `in_ready` are both high at a rising edge, `out_valid` is high after that edge and `result` carries that operation's value.
- R3: With `wide_mode`=0, element i of a segment occupies bits [8i+7:8i]. Lane l occupies bits [32l+31:32l], and its value is acc lane l plus the sum of a[4l+k]*b[4l+k] for k=0..3.
- R4: With `wide_mode`=1, element i of a segment occupies bits [16i+15:16i]. Lane l (l=0,1) occupies bits [64l+63:64l], and its value is acc lane l plus the sum of a[4l+k]*b[4l+k] for k=0..3.
- R5: With `sign_mode`=1, source elements are treated as two's complement values.
- R6: With `sign_mode`=0, source elements are treated as unsigned values.
- R7: The add into each lane wraps modulo 2^32 (narrow) or 2^64 (wide), and no flag is produced.
- R8: Segment s occupies bits [128s+127:128s] of every vector, and its result depends only on that segment's inputs.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `result` holds its value.
- R10: An all-zero `src_a` returns `acc_in` unchanged in `result`.
- R11: The dot sum is exact even for extreme operands, for example four products of -128*-128 giving 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands are present |
| in_ready | output | 1 | Unit can take operands this cycle |
| sign_mode | input | 1 | 1: signed sources, 0: unsigned |
| wide_mode | input | 1 | 0: 8-bit to 32-bit lanes, 1: 16-bit to 64-bit lanes |
| acc_in | input | SEGS*128 | Accumulator vector |
| src_a | input | SEGS*128 | First source vector |
| src_b | input | SEGS*128 | Second source vector |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| result | output | SEGS*128 | Accumulated lanes |

## Verification
Each accepted operation yields its result exactly one rising edge later, and that result stays on the port for as long as `out_ready` is low. The bench mirrors this with a cycle-by-cycle model. At every rising edge the model updates its own valid flag, ready flag and expected vector. All ports are compared at the following falling edge, once every register has settled. Backpressure is applied in random patterns, so the hold and ready timing is checked over many stall lengths.

// File: rtl/dot4_accum.sv
module dot4_accum #(
  parameter int SEGS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  sign_mode,
  input  logic                  wide_mode,
  input  logic [SEGS*128-1:0]   acc_in,
  input  logic [SEGS*128-1:0]   src_a,
  input  logic [SEGS*128-1:0]   src_b,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [SEGS*128-1:0]   result
);
  localparam int SEG_W = 128;
  localparam int VEC_W = SEGS * SEG_W;
  localparam int N_LN  = SEG_W / 32;
  localparam int W_LN  = SEG_W / 64;

  function automatic logic signed [17:0] mul8(input logic [7:0] x, input logic [7:0] y,
                                              input logic sg);
    logic signed [8:0] xe, ye;
    xe = {sg & x[7], x};
    ye = {sg & y[7], y};
    return 18'(xe) * 18'(ye);
  endfunction

  function automatic logic signed [33:0] mul16(input logic [15:0] x, input logic [15:0] y,
                                               input logic sg);
    logic signed [16:0] xe, ye;
    xe = {sg & x[15], x};
    ye = {sg & y[15], y};
    return 34'(xe) * 34'(ye);
  endfunction

  logic [VEC_W-1:0] next_res;

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    logic [SEG_W-1:0] a_s, b_s, c_s, narrow_res, wide_res;
    assign a_s = src_a[SEG_W*s +: SEG_W];
    assign b_s = src_b[SEG_W*s +: SEG_W];
    assign c_s = acc_in[SEG_W*s +: SEG_W];

    for (genvar l = 0; l < N_LN; l++) begin : g_nl
      logic signed [19:0] dp;
      always_comb begin
        dp = '0;
        for (int k = 0; k < 4; k++)
          dp = dp + 20'(mul8(a_s[8*(4*l+k) +: 8], b_s[8*(4*l+k) +: 8], sign_mode));
      end
      assign narrow_res[32*l +: 32] = c_s[32*l +: 32] + 32'(dp);
    end

    for (genvar l = 0; l < W_LN; l++) begin : g_wl
      logic signed [35:0] dp;
      always_comb begin
        dp = '0;
        for (int k = 0; k < 4; k++)
          dp = dp + 36'(mul16(a_s[16*(4*l+k) +: 16], b_s[16*(4*l+k) +: 16], sign_mode));
      end
      assign wide_res[64*l +: 64] = c_s[64*l +: 64] + 64'(dp);
    end

    assign next_res[SEG_W*s +: SEG_W] = wide_mode ? wide_res : narrow_res;
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      result    <= next_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dot4_accum_sva.sv
module dot4_accum_sva #(
  parameter int SEGS = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [SEGS*128-1:0] acc_in,
  input logic [SEGS*128-1:0] src_a,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SEGS*128-1:0] result
);
  p_valid_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !(in_valid && in_ready) |=> !out_valid);

  p_hold_when_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result));

  p_stall_blocks_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_zero_src_passes_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (src_a == '0) |=> result == $past(acc_in));
endmodule

bind dot4_accum dot4_accum_sva #(.SEGS(SEGS)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .acc_in(acc_in), .src_a(src_a), .out_valid(out_valid),
  .out_ready(out_ready), .result(result)
);

// File: tb/dot4_accum_tb_top.sv
module dot4_accum_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SEGS = 2;
  localparam int VW = SEGS * 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, sign_mode = 1'b0, wide_mode = 1'b0, out_ready = 1'b1;
  logic [VW-1:0] acc_in = '0, src_a = '0, src_b = '0;
  logic in_ready, out_valid;
  logic [VW-1:0] result;

  int checks = 0, errors = 0, cycles = 0;
  bit bp_random = 1'b0;
  string cur_tag = "R3";

  always #(CLK_PERIOD/2) clk = ~clk;

  dot4_accum #(.SEGS(SEGS)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .sign_mode(sign_mode), .wide_mode(wide_mode), .acc_in(acc_in),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .out_ready(out_ready), .result(result));

  function automatic logic [VW-1:0] ref_calc(input logic [VW-1:0] c, input logic [VW-1:0] a,
                                             input logic [VW-1:0] b, input bit sg, input bit wd);
    logic [VW-1:0] r;
    for (int s = 0; s < SEGS; s++) begin
      for (int l = 0; l < (wd ? 2 : 4); l++) begin
        longint sum = 0;
        for (int k = 0; k < 4; k++) begin
          longint xa, yb;
          if (wd) begin
            logic [15:0] x = a[16*(s*8+4*l+k) +: 16];
            logic [15:0] y = b[16*(s*8+4*l+k) +: 16];
            xa = sg ? longint'($signed(x)) : longint'(x);
            yb = sg ? longint'($signed(y)) : longint'(y);
          end else begin
            logic [7:0] x = a[8*(s*16+4*l+k) +: 8];
            logic [7:0] y = b[8*(s*16+4*l+k) +: 8];
            xa = sg ? longint'($signed(x)) : longint'(x);
            yb = sg ? longint'($signed(y)) : longint'(y);
          end
          sum += xa * yb;
        end
        if (wd) r[128*s+64*l +: 64] = c[128*s+64*l +: 64] + 64'(sum);
        else    r[128*s+32*l +: 32] = c[128*s+32*l +: 32] + 32'(sum);
      end
    end
    return r;
  endfunction

  // behavioural model
  logic m_valid = 1'b0;
  logic [VW-1:0] m_res = '0;
  string m_tag = "R1";
  logic m_ready;
  assign m_ready = !m_valid || out_ready;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_res   <= '0;
      m_tag   <= "R1";
    end else if (in_valid && m_ready) begin
      m_valid <= 1'b1;
      m_res   <= ref_calc(acc_in, src_a, src_b, sign_mode, wide_mode);
      m_tag   <= cur_tag;
    end else if (out_ready) begin
      m_valid <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (!rst_n) begin
      check(out_valid == 1'b0 && result == '0, "R1", {out_valid, result[VW-2:0]}, '0);
    end else begin
      check(out_valid == m_valid, "R2", VW'(out_valid), VW'(m_valid));
      check(in_ready == m_ready, "R9", VW'(in_ready), VW'(m_ready));
      if (m_valid) check(result == m_res, m_tag, result, m_res);
    end
  end

  always @(negedge clk) begin
    if (bp_random) out_ready <= ($urandom % 3) != 0;
    else out_ready <= 1'b1;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic send(input logic [VW-1:0] c, input logic [VW-1:0] a, input logic [VW-1:0] b,
                      input bit sg, input bit wd, input string tag);
    bit taken = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; acc_in = c; src_a = a; src_b = b;
    sign_mode = sg; wide_mode = wd; cur_tag = tag;
    while (!taken) begin
      #1;
      taken = in_ready;
      @(posedge clk);
      if (!taken) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10 zero source
    send(rnd_vec(), '0, rnd_vec(), 1'b1, 1'b0, "R10");
    // R11 extreme signed narrow: each lane gets 4*16384
    send('0, {VW/8{8'h80}}, {VW/8{8'h80}}, 1'b1, 1'b0, "R11 R5 R3");
    send('0, {VW/16{16'h8000}}, {VW/16{16'h8000}}, 1'b1, 1'b1, "R11 R5 R4");
    // R7 wrap
    send({VW{1'b1}}, {VW/8{8'hFF}}, {VW/8{8'hFF}}, 1'b0, 1'b0, "R7 R6");
    send({VW{1'b1}}, {VW/16{16'hFFFF}}, {VW/16{16'hFFFF}}, 1'b0, 1'b1, "R7 R6 R4");
    // R8 segments differ
    send({rnd_vec()}, {128'h0, {16{8'h03}}}, {128'h0, {16{8'h05}}}, 1'b0, 1'b0, "R8");
    // random mix, no stall then with backpressure
    for (int i = 0; i < 40; i++)
      send(rnd_vec(), rnd_vec(), rnd_vec(), i[0], i[1], i[1] ? "R4" : "R3");
    bp_random = 1'b1;
    for (int i = 0; i < 120; i++)
      send(rnd_vec(), rnd_vec(), rnd_vec(), i[1], i[0], i[1] ? "R5 R9" : "R6 R9");
    bp_random = 1'b0;
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule